// File: doc/BRIEF.md
# SPI Master Transfer Engine

This block is a serial master that empties a byte transmit queue onto MOSI and fills a byte receive queue from MISO. Every byte sent yields exactly one received byte, so a read of N bytes is performed by pushing N bytes (often dummies) into the transmit side. Both queues sit outside the block. The transmit side is a valid/ready pop port. The receive side is a push port whose `rx_ready` input reports that the queue still has room.

SCLK comes from the reference clock through a power-of-two divider. All four combinations of clock polarity and phase are supported. One of three active-low select lines is chosen by a 4-bit priority code, and it is driven either only during a transaction (automatic) or all the time (forced). A transaction starts by itself when a byte is waiting, or, with manual start enabled, only after a start pulse. It then runs for as long as the transmit queue stays non-empty. Programmable gaps are inserted after select assertion and between words.

The configuration inputs must be held stable while `busy` is high.

Top module: `spi_xfer_engine`

## Requirements
- R1: The SCLK half period is 2^N reference cycles, where N is `cfg_div`. Code 0 behaves exactly like code 1, giving a half period of 2 cycles.
- R2: `cfg_sel` is decoded with priority from bit 0 upward. Bit0=0 picks line 0. Bits[1:0]=01 pick line 1. Bits[2:0]=011 pick line 2. 0111 and 1111 pick no line, and then no select line ever goes low.
- R3: At most one bit of `ss_n` is low in any cycle.
- R4: With `cfg_force_sel`=1, the chosen line is low even while idle. With `cfg_force_sel`=0, it is low only during a transaction and returns high exactly H+1 reference cycles after the final SCLK edge, where H is the half period.
- R5: With `cfg_manual_start`=0, a transaction begins when `tx_valid` is high. With it set to 1, no byte is popped and `busy` stays low until a `start_pulse` has been seen. A pulse is remembered until a transaction begins.
- R6: While idle, SCLK rests at `cfg_cpol`. The first edge of each bit moves away from that level. With `cfg_cpha`=0, data is sampled on the first edge and launched on the second. With `cfg_cpha`=1, data is launched on the first edge and sampled on the second. Each byte produces exactly 16 SCLK edges.
- R7: Bytes are sent MSB first. Each received byte is assembled MSB first and offered on `rx_data` with a one-cycle `rx_valid` after its eighth sampled bit.
- R8: After a byte ends, the next byte is popped at once if `tx_valid` is high. Otherwise the transaction ends.
- R9: The first SCLK edge follows the fall of the select line by (2·`cfg_lead_gap`+2)·H−1 reference cycles.
- R10: The last edge of one word and the first edge of the next are (2·`cfg_word_gap`+2)·H reference cycles apart.
- R11: If `rx_ready` is low when a byte completes, that byte is dropped and `rx_overflow` pulses for one cycle instead of `rx_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_div | input | DIV_W | Divider exponent N (0 treated as 1) |
| cfg_cpol | input | 1 | SCLK idle level |
| cfg_cpha | input | 1 | Clock phase select |
| cfg_sel | input | SEL_N+1 | Priority-coded select choice |
| cfg_force_sel | input | 1 | Hold the chosen select low while idle |
| cfg_manual_start | input | 1 | Require a start pulse to begin |
| start_pulse | input | 1 | Start command for manual mode |
| cfg_lead_gap | input | GAP_W | Extra SCLK periods after select assertion |
| cfg_word_gap | input | GAP_W | Extra SCLK periods between words |
| tx_data | input | WORD_W | Head of the transmit queue |
| tx_valid | input | 1 | Transmit queue is non-empty |
| tx_ready | output | 1 | Pop strobe for the transmit queue |
| rx_data | output | WORD_W | Received byte |
| rx_valid | output | 1 | Push strobe for the receive queue |
| rx_ready | input | 1 | Receive queue has room |
| rx_overflow | output | 1 | One-cycle pulse for a dropped byte |
| miso | input | 1 | Serial data from the slave |
| mosi | output | 1 | Serial data to the slave |
| sclk | output | 1 | Serial clock |
| ss_n | output | SEL_N | Active-low select lines |
| busy | output | 1 | A transaction is in progress |

## Verification
A wrong edge counter shows up at the ports within one byte: the edge total per byte differs from 16, and the receive strobe is early or late. A wrong bit order or phase corrupts the very first byte that a slave model captures, and the byte it returns. A divider or gap counter fault moves SCLK edges, and measuring the cycle spacing between edges and select transitions catches it on the first transaction. A select decode or release fault is visible in `ss_n` in the same or the following cycle.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_SHIFT,
    ST_TAIL
  } xfer_state_t;
endpackage

// File: rtl/spi_baud_gen.sv
module spi_baud_gen #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam int CNT_W = 1 << DIV_W;

  logic [CNT_W-1:0] cnt;
  logic [DIV_W-1:0] eff;
  logic [CNT_W-1:0] lim;

  // code 0 is reserved: fall back to the smallest legal divisor
  assign eff  = (div == '0) ? DIV_W'(1) : div;
  assign lim  = (CNT_W'(1) << eff) - CNT_W'(1);
  assign tick = en && (cnt == lim);

  always_ff @(posedge clk) begin
    if (rst || !en || tick) cnt <= '0;
    else                    cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/spi_sel_drive.sv
module spi_sel_drive #(
  parameter int SEL_N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [SEL_N:0] code,
  input  logic         drive,
  output logic [SEL_N-1:0] ss_n
);
  logic [SEL_N-1:0] hit;

  // lowest zero bit wins; all-ones in the low SEL_N bits selects nothing
  for (genvar i = 0; i < SEL_N; i++) begin : g_dec
    if (i == 0) begin : g_first
      assign hit[i] = ~code[0];
    end else begin : g_rest
      assign hit[i] = ~code[i] & (&code[i-1:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ss_n <= '1;
    else     ss_n <= ~(hit & {SEL_N{drive}});
  end
endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
  import spi_xfer_pkg::*;
#(
  parameter int DIV_W  = 4,
  parameter int GAP_W  = 8,
  parameter int SEL_N  = 3,
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic [SEL_N:0]    cfg_sel,
  input  logic              cfg_force_sel,
  input  logic              cfg_manual_start,
  input  logic              start_pulse,
  input  logic [GAP_W-1:0]  cfg_lead_gap,
  input  logic [GAP_W-1:0]  cfg_word_gap,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic              rx_overflow,
  input  logic              miso,
  output logic              mosi,
  output logic              sclk,
  output logic [SEL_N-1:0]  ss_n,
  output logic              busy
);
  localparam int EDGES     = 2 * WORD_W;
  localparam int EDGE_W    = $clog2(EDGES);
  localparam int WAIT_W    = GAP_W + 2;
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(EDGES - 1);

  xfer_state_t       state;
  logic [EDGE_W-1:0] edge_cnt;
  logic [WAIT_W-1:0] wait_cnt, wait_lim;
  logic [WORD_W-1:0] tx_sh, rx_sh, rx_final;
  logic              start_req, sclk_q, mosi_q;
  logic              tick, leading, begin_xfer, word_end, launch_ok;
  logic [WAIT_W-1:0] lead_lim, word_lim;

  assign lead_lim   = {1'b0, cfg_lead_gap, 1'b1};
  assign word_lim   = {1'b0, cfg_word_gap, 1'b1};
  assign leading    = ~edge_cnt[0];
  assign launch_ok  = cfg_manual_start ? (start_req | start_pulse) : 1'b1;
  assign begin_xfer = (state == ST_IDLE) && tx_valid && launch_ok;
  assign word_end   = (state == ST_SHIFT) && tick && (edge_cnt == LAST_EDGE);
  assign tx_ready   = begin_xfer || (word_end && tx_valid);
  assign rx_final   = cfg_cpha ? {rx_sh[WORD_W-2:0], miso} : rx_sh;
  assign busy       = (state != ST_IDLE);
  assign sclk       = sclk_q;
  assign mosi       = mosi_q;

  spi_baud_gen #(.DIV_W(DIV_W)) u_baud (
    .clk (clk),
    .rst (rst),
    .en  (busy),
    .div (cfg_div),
    .tick(tick)
  );

  spi_sel_drive #(.SEL_N(SEL_N)) u_sel (
    .clk  (clk),
    .rst  (rst),
    .code (cfg_sel),
    .drive(cfg_force_sel | busy),
    .ss_n (ss_n)
  );

  always_ff @(posedge clk) begin
    if (rst)             start_req <= 1'b0;
    else if (begin_xfer) start_req <= 1'b0;
    else if (start_pulse) start_req <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      edge_cnt    <= '0;
      wait_cnt    <= '0;
      wait_lim    <= '0;
      tx_sh       <= '0;
      rx_sh       <= '0;
      mosi_q      <= 1'b0;
      sclk_q      <= 1'b0;
      rx_data     <= '0;
      rx_valid    <= 1'b0;
      rx_overflow <= 1'b0;
    end else begin
      rx_valid    <= 1'b0;
      rx_overflow <= 1'b0;
      case (state)
        ST_IDLE: begin
          sclk_q <= cfg_cpol;
          if (begin_xfer) begin
            mosi_q   <= tx_data[WORD_W-1];
            tx_sh    <= cfg_cpha ? tx_data : (tx_data << 1);
            state    <= ST_WAIT;
            wait_cnt <= '0;
            wait_lim <= lead_lim;
            edge_cnt <= '0;
          end
        end
        ST_WAIT: begin
          if (tick) begin
            if (wait_cnt == wait_lim - WAIT_W'(1)) begin
              wait_cnt <= '0;
              state    <= ST_SHIFT;
            end else begin
              wait_cnt <= wait_cnt + WAIT_W'(1);
            end
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            sclk_q   <= ~sclk_q;
            edge_cnt <= edge_cnt + EDGE_W'(1);
            if (leading ^ cfg_cpha) rx_sh <= {rx_sh[WORD_W-2:0], miso};
            if ((cfg_cpha && leading) ||
                (!cfg_cpha && !leading && edge_cnt != LAST_EDGE)) begin
              mosi_q <= tx_sh[WORD_W-1];
              tx_sh  <= tx_sh << 1;
            end
            if (edge_cnt == LAST_EDGE) begin
              edge_cnt <= '0;
              if (rx_ready) begin
                rx_valid <= 1'b1;
                rx_data  <= rx_final;
              end else begin
                rx_overflow <= 1'b1;
              end
              if (tx_valid) begin
                // phase 1 launches on the next leading edge, so MOSI waits
                if (!cfg_cpha) mosi_q <= tx_data[WORD_W-1];
                tx_sh    <= cfg_cpha ? tx_data : (tx_data << 1);
                state    <= ST_WAIT;
                wait_cnt <= '0;
                wait_lim <= word_lim;
              end else begin
                state <= ST_TAIL;
              end
            end
          end
        end
        ST_TAIL: begin
          if (tick) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_xfer_engine_chk.sv
module spi_xfer_engine_chk #(
  parameter int SEL_N = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_cpol,
  input logic             cfg_force_sel,
  input logic             busy,
  input logic             sclk,
  input logic [SEL_N-1:0] ss_n,
  input logic             rx_valid,
  input logic             rx_overflow
);
  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (rst)
    $countones(~ss_n) <= 1); // R3

  AST_AUTO_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (!cfg_force_sel && !busy) |=> (&ss_n)); // R4

  AST_IDLE_SCLK: assert property (@(posedge clk) disable iff (rst)
    !busy |=> (sclk == $past(cfg_cpol))); // R6

  AST_DROP_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(rx_valid && rx_overflow)); // R11

  AST_OVF_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rx_overflow |=> !rx_overflow); // R11
endmodule

bind spi_xfer_engine spi_xfer_engine_chk #(.SEL_N(SEL_N)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cfg_cpol     (cfg_cpol),
  .cfg_force_sel(cfg_force_sel),
  .busy         (busy),
  .sclk         (sclk),
  .ss_n         (ss_n),
  .rx_valid     (rx_valid),
  .rx_overflow  (rx_overflow)
);

// File: tb/spi_xfer_engine_test.sv
module spi_xfer_engine_test;
  localparam int DIV_W = 4, GAP_W = 8, SEL_N = 3, WORD_W = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1;
  logic [DIV_W-1:0] cfg_div = '0;
  logic cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_force_sel = 1'b0, cfg_manual_start = 1'b0;
  logic start_pulse = 1'b0;
  logic [SEL_N:0] cfg_sel = '1;
  logic [GAP_W-1:0] cfg_lead_gap = '0, cfg_word_gap = '0;
  logic [WORD_W-1:0] tx_data = '0;
  logic tx_valid = 1'b0, rx_ready = 1'b1, miso = 1'b0;
  logic tx_ready, rx_valid, rx_overflow, mosi, sclk, busy;
  logic [WORD_W-1:0] rx_data;
  logic [SEL_N-1:0] ss_n;

  spi_xfer_engine #(.DIV_W(DIV_W), .GAP_W(GAP_W), .SEL_N(SEL_N), .WORD_W(WORD_W)) uut (
    .clk(clk), .rst(rst), .cfg_div(cfg_div), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .cfg_sel(cfg_sel), .cfg_force_sel(cfg_force_sel), .cfg_manual_start(cfg_manual_start),
    .start_pulse(start_pulse), .cfg_lead_gap(cfg_lead_gap), .cfg_word_gap(cfg_word_gap),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_overflow(rx_overflow), .miso(miso),
    .mosi(mosi), .sclk(sclk), .ss_n(ss_n), .busy(busy)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // transmit queue model: pops on a cycle where valid and ready meet
  logic [7:0] tx_q[$];
  bit pend = 0;
  initial forever begin
    @(negedge clk);
    if (pend) begin void'(tx_q.pop_front()); pend = 0; end
    tx_valid = (tx_q.size() > 0);
    tx_data  = tx_valid ? tx_q[0] : 8'h00;
    #1;
    pend = tx_valid && tx_ready && !rst;
  end

  // per-cycle monitor and reference of the idle clock level
  int cyc = 0, ss_fall = 0, ss_rise = 0, ovf_cnt = 0, idle_bad = 0;
  int edge_t[$];
  logic [7:0] rx_got[$];
  logic prev_sclk = 1'b0, cpol_d = 1'b0, first_val = 1'b0;
  logic [SEL_N-1:0] prev_ss = '1, seen = '0;
  initial forever begin
    @(negedge clk);
    cyc++;
    if (!rst) begin
      if (sclk !== prev_sclk) begin
        if (edge_t.size() == 0) first_val = sclk;
        edge_t.push_back(cyc);
      end
      if (prev_ss == '1 && ss_n != '1) ss_fall = cyc;
      if (prev_ss != '1 && ss_n == '1) ss_rise = cyc;
      seen |= ~ss_n;
      if (rx_valid) rx_got.push_back(rx_data);
      if (rx_overflow) ovf_cnt++;
      if (!busy && sclk !== cpol_d) idle_bad++;
    end
    prev_sclk = sclk;
    prev_ss   = ss_n;
    cpol_d    = cfg_cpol;
  end

  // behavioural slave: responds to SCLK edges in the configured mode
  logic [7:0] slv_q[$];
  logic [7:0] slv_got[$];
  logic [7:0] sb = 8'h00, rcv = 8'h00;
  int scnt = 0;
  bit slv_on = 0, s_cpha = 0;

  function automatic logic [7:0] slv_next();
    if (slv_q.size() > 0) return slv_q.pop_front();
    return 8'h00;
  endfunction

  initial forever begin
    @(sclk);
    if (slv_on) begin
      if ((scnt % 2 == 0) == !s_cpha) begin
        rcv = {rcv[6:0], mosi};
      end else if (s_cpha) begin
        miso = sb[7];
        sb   = sb << 1;
      end else if (scnt != 15) begin
        sb   = sb << 1;
        miso = sb[7];
      end
      scnt++;
      if (scnt == 16) begin
        slv_got.push_back(rcv);
        scnt = 0;
        sb   = slv_next();
        if (!s_cpha) miso = sb[7];
      end
    end
  end

  task automatic run(string tag, int mode, int div, logic [3:0] code, int line,
                     int lead, int wg, int n, bit manual, bit rxr,
                     logic [7:0] b0, logic [7:0] b1, logic [7:0] b2);
    logic [7:0] m[3];
    int h;
    m[0] = b0; m[1] = b1; m[2] = b2;
    h = 1 << ((div == 0) ? 1 : div);
    @(posedge clk); #1;
    cfg_cpol = mode[1]; cfg_cpha = mode[0]; cfg_div = DIV_W'(div); cfg_sel = code;
    cfg_lead_gap = GAP_W'(lead); cfg_word_gap = GAP_W'(wg);
    cfg_manual_start = manual; rx_ready = rxr;
    repeat (4) @(negedge clk);
    edge_t.delete(); rx_got.delete(); slv_got.delete(); slv_q.delete();
    seen = '0; ovf_cnt = 0; idle_bad = 0;
    s_cpha = mode[0]; scnt = 0; rcv = 8'h00;
    for (int i = 0; i < n; i++) slv_q.push_back(m[i] ^ 8'hA5);
    sb = slv_next(); miso = sb[7];
    slv_on = 1;
    for (int i = 0; i < n; i++) tx_q.push_back(m[i]);
    if (manual) begin
      repeat (40) @(negedge clk);
      check("R5", {tag, " busy before start pulse"}, int'(busy), 0);
      check("R5", {tag, " bytes left before start pulse"}, tx_q.size(), n);
      @(posedge clk); #1 start_pulse = 1'b1;
      @(posedge clk); #1 start_pulse = 1'b0;
    end
    wait (busy === 1'b1);
    wait (busy === 1'b0);
    repeat (6) @(negedge clk);
    slv_on = 0;
    rx_ready = 1'b1;
    check("R6", {tag, " edge count"}, edge_t.size(), 16 * n);
    check("R6", {tag, " first edge leaves idle level"}, int'(first_val), int'(!mode[1]));
    check("R6", {tag, " idle level mismatches"}, idle_bad, 0);
    if (edge_t.size() >= 2)
      check("R1", {tag, " half period"}, edge_t[1] - edge_t[0], h);
    for (int i = 0; i < n; i++)
      if (slv_got.size() > i) check("R7", {tag, " byte at slave"}, slv_got[i], m[i]);
    if (rxr) begin
      check("R7", {tag, " received count"}, rx_got.size(), n);
      for (int i = 0; i < n; i++)
        if (rx_got.size() > i) check("R7", {tag, " received byte"}, rx_got[i], m[i] ^ 8'hA5);
    end else begin
      check("R11", {tag, " dropped bytes pulsed"}, ovf_cnt, n);
      check("R11", {tag, " nothing pushed"}, rx_got.size(), 0);
    end
    if (n > 1 && edge_t.size() >= 17)
      check("R10", {tag, " word gap"}, edge_t[16] - edge_t[15], (2 * wg + 2) * h);
    check("R8", {tag, " queue drained"}, tx_q.size(), 0);
    if (line >= 0) begin
      check("R2", {tag, " select line used"}, int'(seen), 1 << line);
      if (edge_t.size() > 0) begin
        check("R9", {tag, " lead gap"}, edge_t[0] - ss_fall, (2 * lead + 2) * h - 1);
        check("R4", {tag, " select release"}, ss_rise - edge_t[edge_t.size() - 1], h + 1);
      end
    end else begin
      check("R2", {tag, " no select line used"}, int'(seen), 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    repeat (2) @(negedge clk);
    check("R4", "reset select lines", int'(ss_n), 7);
    check("R6", "reset sclk level", int'(sclk), 0);
    check("R5", "reset busy", int'(busy), 0);
    check("R7", "reset rx_valid", int'(rx_valid), 0);

    run("mode0 div0", 0, 0, 4'b1110, 0, 0, 0, 3, 0, 1, 8'hC3, 8'h5A, 8'h01);
    run("mode1 line1", 1, 1, 4'b1001, 1, 1, 2, 2, 0, 1, 8'h80, 8'h7E, 8'h00);
    run("mode2 line2", 2, 2, 4'b0011, 2, 0, 1, 2, 0, 1, 8'h96, 8'hFF, 8'h00);
    run("mode3 line0", 3, 2, 4'b1010, 0, 2, 0, 2, 0, 1, 8'h3C, 8'hE1, 8'h00);
    run("mode3 none", 3, 1, 4'b1111, -1, 0, 0, 2, 0, 1, 8'h12, 8'h34, 8'h00);
    run("reserved manual", 0, 1, 4'b0111, -1, 0, 0, 1, 1, 1, 8'hA7, 8'h00, 8'h00);
    run("manual line1", 1, 0, 4'b1101, 1, 0, 0, 2, 1, 1, 8'h0F, 8'hF0, 8'h00);
    run("overflow", 1, 0, 4'b1110, 0, 0, 0, 2, 0, 0, 8'h55, 8'hAA, 8'h00);

    @(posedge clk); #1 cfg_sel = 4'b1101; cfg_force_sel = 1'b1;
    repeat (3) @(negedge clk);
    check("R4", "forced select while idle", int'(ss_n), 5);
    @(posedge clk); #1 cfg_force_sel = 1'b0;
    repeat (3) @(negedge clk);
    check("R4", "automatic select while idle", int'(ss_n), 7);
    summary();
  end
endmodule